// File: doc/BRIEF.md
# SPDIF Receive Sample Word Formatter

This block sits between a biphase decoder and a receive data FIFO. Each cycle the decoder may present one decoded subframe. A subframe carries a 4-bit preamble code, a 4-bit auxiliary nibble, a 20-bit audio field and the parity, channel-status, user and validity flags. The block turns accepted subframes into 32-bit words and offers them on a valid/ready stream. The layout of each word depends on a 2-bit format select and a pack-enable bit.

In packed 16-bit operation, two subframes (one left, one right) share one output word. A start-channel control decides which channel capture begins on after the receiver is enabled. Subframes that arrive before the first subframe of that channel are thrown away. The block does not stall: if a word completes while the previous one is still waiting for the consumer, the new word is lost and a one-cycle overrun pulse is raised.

Top module: `spdif_rx_word_fmt`

## Requirements
- R1: After reset, `wordValid` and `overrunPulse` are 0.
- R2: With format select 0 (16-bit), an accepted subframe gives the following word. Bits 31:28 hold {parity, channel status, user, validity}. Bits 27:24 hold the preamble code. Bits 23:16 are zero. Bits 15:0 hold audio[19:4].
- R3: With format select 1 (20-bit), bits 31:24 are as in R2, bits 23:20 are zero and bits 19:0 hold audio[19:0].
- R4: With format select 2 (24-bit), bits 31:24 are as in R2 and bits 23:0 hold {audio[19:0], aux[3:0]}.
- R5: With format select 3 (raw), bits 31:28 hold {parity, channel status, user, validity}, bits 27:8 hold audio, bits 7:4 hold aux and bits 3:0 hold the preamble code.
- R6: With pack enabled and format select 0, no word is produced for the first subframe of a pair. The second subframe produces one word. The right sample (audio[19:4]) goes in bits 31:16 and the left sample goes in bits 15:0, whichever channel arrived first.
- R7: Pack enable has no effect when the format select is not 0. Each subframe then yields one word, formatted as in R3 to R5.
- R8: Preamble codes 4'h1 and 4'h2 mark a left subframe and 4'h4 marks a right subframe. Any other code is discarded. After the receiver is enabled, subframes are discarded until the first subframe of the start channel (`startLeft` = 1 selects left, 0 selects right). That subframe and all later ones are accepted.
- R9: While `rxEnable` is 0, subframes are ignored and capture is disarmed. A half-collected pair is discarded, so it never appears in a later word.
- R10: If a word completes while `wordValid` is 1 and `wordReady` is 0, that word is dropped, the pending word is unchanged and `overrunPulse` is 1 for one cycle.
- R11: A pending word keeps `wordValid` high and `wordData` stable until `wordReady` is seen. An accepted word with no new word in the same cycle clears `wordValid` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receiver enable; low disarms capture |
| bitMode | input | 2 | Word format select (0:16, 1:20, 2:24, 3:raw) |
| packEnable | input | 1 | Two 16-bit samples per word (format 0 only) |
| startLeft | input | 1 | Capture start channel: 1 left, 0 right |
| sfValid | input | 1 | Decoded subframe present this cycle |
| sfPreamble | input | 4 | Preamble code of the subframe |
| sfAux | input | 4 | Auxiliary nibble |
| sfAudio | input | 20 | Audio field |
| sfValidity | input | 1 | Validity flag |
| sfUser | input | 1 | User data bit |
| sfChStat | input | 1 | Channel status bit |
| sfParity | input | 1 | Parity bit |
| wordReady | input | 1 | Consumer accepts the word |
| wordValid | output | 1 | Output word is pending |
| wordData | output | 32 | Formatted output word |
| overrunPulse | output | 1 | One-cycle pulse when a completed word is dropped |

## Verification
The hardest case to reach from the ports is a half-collected pair that must disappear when the receiver is switched off. To provoke it, the stimulus feeds one left subframe in packed mode and then drops `rxEnable`. It re-enables the receiver and sends a right subframe, which capture must refuse because it is not yet armed. It then sends a fresh left/right pair and checks that only the fresh pair shows up in the word. Overrun is reached by holding `wordReady` low across two back-to-back unpacked subframes, with the pending word checked for stability while the pulse is high.

// File: rtl/spdif_rx_fmt_pkg.sv
`timescale 1ns/1ps
package spdif_rx_fmt_pkg;
  localparam int AUDIO_W = 20;
  localparam int AUX_W   = 4;
  localparam int PRE_W   = 4;
  localparam int FLAG_W  = 4;
  localparam int WORD_W  = FLAG_W + AUDIO_W + AUX_W + PRE_W;
  localparam int HALF_W  = WORD_W / 2;

  typedef enum logic [1:0] {
    FMT_16  = 2'd0,
    FMT_20  = 2'd1,
    FMT_24  = 2'd2,
    FMT_RAW = 2'd3
  } fmtSel_t;

  localparam logic [PRE_W-1:0] PRE_BLOCK = 4'h1;
  localparam logic [PRE_W-1:0] PRE_LEFT  = 4'h2;
  localparam logic [PRE_W-1:0] PRE_RIGHT = 4'h4;

  typedef struct packed {
    logic loadHold;
    logic emitSingle;
    logic emitPair;
    logic loadOut;
    logic curIsLeft;
  } fmtStrobe_t;
endpackage

// File: rtl/spdif_rx_fmt_ctrl.sv
`timescale 1ns/1ps
module spdif_rx_fmt_ctrl
  import spdif_rx_fmt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic [1:0]       bitMode,
  input  logic             packEnable,
  input  logic             startLeft,
  input  logic             sfValid,
  input  logic [PRE_W-1:0] sfPreamble,
  input  logic             wordReady,
  output fmtStrobe_t       strobe,
  output logic             wordValid,
  output logic             overrunPulse
);
  logic armed, halfFull;
  logic isLeft, isRight, startMatch, accept, packEff, complete, hasRoom;

  always_comb begin
    isLeft     = (sfPreamble == PRE_BLOCK) || (sfPreamble == PRE_LEFT);
    isRight    = (sfPreamble == PRE_RIGHT);
    startMatch = startLeft ? isLeft : isRight;
    accept     = rxEnable && sfValid && (isLeft || isRight) && (armed || startMatch);
    packEff    = packEnable && (fmtSel_t'(bitMode) == FMT_16);
    strobe.loadHold   = accept && packEff && !halfFull;
    strobe.emitPair   = accept && packEff && halfFull;
    strobe.emitSingle = accept && !packEff;
    strobe.curIsLeft  = isLeft;
    complete = strobe.emitPair || strobe.emitSingle;
    hasRoom  = !wordValid || wordReady;
    strobe.loadOut = complete && hasRoom;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed        <= 1'b0;
      halfFull     <= 1'b0;
      wordValid    <= 1'b0;
      overrunPulse <= 1'b0;
    end else begin
      armed <= rxEnable ? (armed || accept) : 1'b0;
      if (!rxEnable || !packEff)   halfFull <= 1'b0;
      else if (strobe.loadHold)    halfFull <= 1'b1;
      else if (strobe.emitPair)    halfFull <= 1'b0;
      if (strobe.loadOut)          wordValid <= 1'b1;
      else if (wordReady)          wordValid <= 1'b0;
      overrunPulse <= complete && !hasRoom;
    end
  end

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |-> $past(wordValid && !wordReady)); // R10

  AST_WORD_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordValid) |-> $past(rxEnable && sfValid)); // R9

  AST_PAIR_FIRST_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && sfValid && packEff && !halfFull) |=> (!$rose(wordValid) && !overrunPulse)); // R6
endmodule

// File: rtl/spdif_rx_fmt_dp.sv
`timescale 1ns/1ps
module spdif_rx_fmt_dp
  import spdif_rx_fmt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  fmtStrobe_t         strobe,
  input  logic [1:0]         bitMode,
  input  logic [PRE_W-1:0]   sfPreamble,
  input  logic [AUX_W-1:0]   sfAux,
  input  logic [AUDIO_W-1:0] sfAudio,
  input  logic               sfValidity,
  input  logic               sfUser,
  input  logic               sfChStat,
  input  logic               sfParity,
  output logic [WORD_W-1:0]  wordData
);
  localparam int PAD16 = WORD_W - FLAG_W - PRE_W - HALF_W;
  localparam int PAD20 = WORD_W - FLAG_W - PRE_W - AUDIO_W;

  logic [HALF_W-1:0] holdSample;
  logic              holdIsLeft;
  logic [HALF_W-1:0] curSample;
  logic [FLAG_W-1:0] flags;
  logic [WORD_W-1:0] singleWord, pairWord;

  always_comb begin
    curSample = sfAudio[AUDIO_W-1 -: HALF_W];
    flags     = {sfParity, sfChStat, sfUser, sfValidity};
    case (fmtSel_t'(bitMode))
      FMT_16:  singleWord = {flags, sfPreamble, {PAD16{1'b0}}, curSample};
      FMT_20:  singleWord = {flags, sfPreamble, {PAD20{1'b0}}, sfAudio};
      FMT_24:  singleWord = {flags, sfPreamble, sfAudio, sfAux};
      default: singleWord = {flags, sfAudio, sfAux, sfPreamble};
    endcase
    pairWord = holdIsLeft ? {curSample, holdSample} : {holdSample, curSample};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdSample <= '0;
      holdIsLeft <= 1'b0;
      wordData   <= '0;
    end else begin
      if (strobe.loadHold) begin
        holdSample <= curSample;
        holdIsLeft <= strobe.curIsLeft;
      end
      if (strobe.loadOut)
        wordData <= strobe.emitPair ? pairWord : singleWord;
    end
  end

  AST_HOLD_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadHold |=> $stable(holdSample)); // R6
endmodule

// File: rtl/spdif_rx_word_fmt.sv
`timescale 1ns/1ps
module spdif_rx_word_fmt
  import spdif_rx_fmt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxEnable,
  input  logic [1:0]         bitMode,
  input  logic               packEnable,
  input  logic               startLeft,
  input  logic               sfValid,
  input  logic [PRE_W-1:0]   sfPreamble,
  input  logic [AUX_W-1:0]   sfAux,
  input  logic [AUDIO_W-1:0] sfAudio,
  input  logic               sfValidity,
  input  logic               sfUser,
  input  logic               sfChStat,
  input  logic               sfParity,
  input  logic               wordReady,
  output logic               wordValid,
  output logic [WORD_W-1:0]  wordData,
  output logic               overrunPulse
);
  fmtStrobe_t strobe;

  spdif_rx_fmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .bitMode(bitMode),
    .packEnable(packEnable), .startLeft(startLeft), .sfValid(sfValid),
    .sfPreamble(sfPreamble), .wordReady(wordReady), .strobe(strobe),
    .wordValid(wordValid), .overrunPulse(overrunPulse)
  );

  spdif_rx_fmt_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitMode(bitMode),
    .sfPreamble(sfPreamble), .sfAux(sfAux), .sfAudio(sfAudio),
    .sfValidity(sfValidity), .sfUser(sfUser), .sfChStat(sfChStat),
    .sfParity(sfParity), .wordData(wordData)
  );

  AST_PENDING_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordReady) |=> (wordValid && $stable(wordData))); // R11

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> (!wordValid && !overrunPulse)); // R1
endmodule

// File: tb/spdif_rx_word_fmt_bench.sv
`timescale 1ns/1ps
module spdif_rx_word_fmt_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0, packEnable = 1'b0, startLeft = 1'b1;
  logic [1:0] bitMode = 2'd0;
  logic sfValid = 1'b0;
  logic [3:0] sfPreamble = 4'h0, sfAux = 4'h0;
  logic [19:0] sfAudio = 20'h0;
  logic sfValidity = 1'b0, sfUser = 1'b0, sfChStat = 1'b0, sfParity = 1'b0;
  logic wordReady = 1'b1;
  logic wordValid, overrunPulse;
  logic [31:0] wordData;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  spdif_rx_word_fmt u_spdif_rx_word_fmt (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .bitMode(bitMode),
    .packEnable(packEnable), .startLeft(startLeft), .sfValid(sfValid),
    .sfPreamble(sfPreamble), .sfAux(sfAux), .sfAudio(sfAudio),
    .sfValidity(sfValidity), .sfUser(sfUser), .sfChStat(sfChStat),
    .sfParity(sfParity), .wordReady(wordReady), .wordValid(wordValid),
    .wordData(wordData), .overrunPulse(overrunPulse)
  );

  // {mode, pack, preamble, aux, audio, {P,C,U,V}, expected word}
  localparam int NVEC = 8;
  localparam logic [66:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 4'h1, 4'h5, 20'hABCDE, 4'b1010, 32'hA100ABCD},  // R2
    {2'd1, 1'b0, 4'h4, 4'h3, 20'h12345, 4'b0101, 32'h54012345},  // R3
    {2'd2, 1'b0, 4'h2, 4'h9, 20'hFEDCB, 4'b1111, 32'hF2FEDCB9},  // R4
    {2'd3, 1'b0, 4'h4, 4'h6, 20'h13579, 4'b0011, 32'h31357964},  // R5
    {2'd0, 1'b0, 4'h4, 4'h0, 20'h0000F, 4'b0000, 32'h04000000},  // R2
    {2'd3, 1'b0, 4'h1, 4'hF, 20'hFFFFF, 4'b1000, 32'h8FFFFFF1},  // R5
    {2'd2, 1'b1, 4'h2, 4'h1, 20'h00001, 4'b0100, 32'h42000011},  // R7
    {2'd1, 1'b1, 4'h1, 4'h7, 20'h80000, 4'b0001, 32'h11080000}   // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendSf(input logic [3:0] pre, input logic [3:0] aux,
                        input logic [19:0] audio, input logic [3:0] pcuv);
    @(negedge clk);
    sfValid = 1'b1; sfPreamble = pre; sfAux = aux; sfAudio = audio;
    {sfParity, sfChStat, sfUser, sfValidity} = pcuv;
    @(negedge clk);
    sfValid = 1'b0;
  endtask

  task automatic rearm(input logic left);
    @(negedge clk);
    rxEnable = 1'b0; startLeft = left;
    @(negedge clk);
    rxEnable = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 valid", {31'b0, wordValid}, 32'h0);
    check("R1 overrun", {31'b0, overrunPulse}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {31'b0, wordValid}, 32'h0);

    // table walk: armed by first entry (left code, start on left)
    rxEnable = 1'b1; startLeft = 1'b1; wordReady = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      bitMode = VEC[i][66:65]; packEnable = VEC[i][64];
      sendSf(VEC[i][63:60], VEC[i][59:56], VEC[i][55:36], VEC[i][35:32]);
      check($sformatf("R2-R7 vec%0d valid", i), {31'b0, wordValid}, 32'h1);
      check($sformatf("vec%0d data R2 R3 R4 R5 R7", i), wordData, VEC[i][31:0]);
    end

    // R8 start channel right, bad code and left discarded
    @(negedge clk); bitMode = 2'd1; packEnable = 1'b0;
    rearm(1'b0);
    sendSf(4'h3, 4'h0, 20'h11111, 4'b0000);
    check("R8 bad code", {31'b0, wordValid}, 32'h0);
    sendSf(4'h2, 4'h0, 20'h22222, 4'b0000);
    check("R8 left before right start", {31'b0, wordValid}, 32'h0);
    sendSf(4'h4, 4'h0, 20'h33333, 4'b0000);
    check("R8 right arms", wordData, 32'h04033333);
    check("R8 right valid", {31'b0, wordValid}, 32'h1);
    sendSf(4'h2, 4'h0, 20'h44444, 4'b0000);
    check("R8 left after arm", wordData, 32'h02044444);

    // R6 packed, start left
    @(negedge clk); bitMode = 2'd0; packEnable = 1'b1;
    rearm(1'b1);
    sendSf(4'h4, 4'h0, 20'h99990, 4'b0000);
    check("R6 R8 right before arm", {31'b0, wordValid}, 32'h0);
    sendSf(4'h1, 4'h0, 20'hAAAA0, 4'b0000);
    check("R6 first half silent", {31'b0, wordValid}, 32'h0);
    sendSf(4'h4, 4'h0, 20'h55550, 4'b0000);
    check("R6 pair valid", {31'b0, wordValid}, 32'h1);
    check("R6 pair left-first", wordData, 32'h5555AAAA);

    // R6 packed, start right
    rearm(1'b0);
    sendSf(4'h4, 4'h0, 20'h12340, 4'b0000);
    check("R6 first half silent right", {31'b0, wordValid}, 32'h0);
    sendSf(4'h2, 4'h0, 20'h56780, 4'b0000);
    check("R6 pair right-first", wordData, 32'h12345678);

    // R9 half pair discarded by disable
    rearm(1'b1);
    sendSf(4'h1, 4'h0, 20'hDEAD0, 4'b0000);
    @(negedge clk); rxEnable = 1'b0;
    sendSf(4'h4, 4'h0, 20'hBEEF0, 4'b0000);
    check("R9 disabled ignored", {31'b0, wordValid}, 32'h0);
    @(negedge clk); rxEnable = 1'b1;
    sendSf(4'h4, 4'h0, 20'hC0DE0, 4'b0000);
    check("R9 disarmed after enable", {31'b0, wordValid}, 32'h0);
    sendSf(4'h2, 4'h0, 20'h01230, 4'b0000);
    check("R9 new first half", {31'b0, wordValid}, 32'h0);
    sendSf(4'h4, 4'h0, 20'h45670, 4'b0000);
    check("R9 fresh pair only", wordData, 32'h45670123);

    // R10 / R11 overrun with consumer stalled
    @(negedge clk); bitMode = 2'd1; packEnable = 1'b0; wordReady = 1'b0;
    sendSf(4'h2, 4'h0, 20'hAAAAA, 4'b0000);
    check("R11 pending valid", {31'b0, wordValid}, 32'h1);
    check("R11 pending data", wordData, 32'h020AAAAA);
    sendSf(4'h4, 4'h0, 20'hBBBBB, 4'b0000);
    check("R10 overrun pulse", {31'b0, overrunPulse}, 32'h1);
    check("R10 pending kept", wordData, 32'h020AAAAA);
    @(negedge clk);
    check("R10 pulse one cycle", {31'b0, overrunPulse}, 32'h0);
    check("R11 still valid", {31'b0, wordValid}, 32'h1);
    check("R11 still stable", wordData, 32'h020AAAAA);
    wordReady = 1'b1;
    @(negedge clk);
    check("R11 cleared after accept", {31'b0, wordValid}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule